// File: doc/BRIEF.md
# Value Block Arithmetic Engine

The engine keeps a 32-bit working register and operates on 16-byte value blocks held in a local synchronous block memory. A command supplies an operation, a block address, a transfer address and a 32-bit operand. Increment and decrement read a source block and check its redundant encoding. They then add or subtract the operand in two's complement, load the sum into the register, and write it as a freshly encoded value block to the transfer address. Restore loads the register from a block. Transfer stores the register into a block.

Each stored block carries its value three times, once inverted, and its own address four times, alternating plain and inverted. The engine rejects any source block whose copies disagree. It also refuses to write the first block of memory or the last block of any sector, because those hold fixed or trailer data. A single-cycle done pulse returns a two-bit status for every accepted command.

Top module: `vb_engine`

## Requirements
- R1: After reset `cmd_ready` is 1, `done` is 0, `acc_value` is 0 and `mem_en` is 0.
- R2: Every written block has this layout: bits [31:0] hold the value, least significant byte first (byte 0 = bits [7:0]). Bits [63:32] hold its bitwise inverse and bits [95:64] the value again. Bits [103:96] hold the address byte (block address zero-extended to 8 bits), [111:104] its inverse, [119:112] the address byte and [127:120] its inverse.
- R3: Increment (`cmd_op`=0) reads `cmd_blk`, adds `cmd_operand`, loads the sum into `acc_value`, writes it to `cmd_xfer` and ends with status 0, with `done` 4 cycles after the accepting edge.
- R4: Decrement (`cmd_op`=1) behaves as increment but subtracts `cmd_operand`.
- R5: A target that is block 0, or whose index modulo 4 (the sector size) is 3, is refused with status 3 on the cycle after acceptance. No memory access is made and the register is unchanged. For increment and decrement the target is `cmd_xfer`, for transfer it is `cmd_blk`. This check wins over every other error.
- R6: Signed 32-bit overflow on increment or decrement gives status 2, leaves `acc_value` unchanged and writes nothing.
- R7: A source block whose value, inverse or address copies disagree gives status 1, leaves the register unchanged and writes nothing. This check wins over overflow.
- R8: Restore (`cmd_op`=2) loads the value of a well-formed `cmd_blk` into `acc_value` with status 0 and writes nothing.
- R9: Transfer (`cmd_op`=3) writes `acc_value`, encoded per R2, into `cmd_blk` with status 0.
- R10: While a command is in progress `cmd_ready` is 0 and `cmd_valid` is ignored.
- R11: `done` is a one-cycle pulse, after which `cmd_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_op | input | 2 | 0 increment, 1 decrement, 2 restore, 3 transfer |
| cmd_blk | input | ADDR_W | Source block (target for transfer) |
| cmd_xfer | input | ADDR_W | Destination of increment/decrement result |
| cmd_operand | input | 32 | Signed operand |
| done | output | 1 | Command finished, one cycle |
| status | output | 2 | 0 ok, 1 bad format, 2 overflow, 3 protected |
| acc_value | output | 32 | Working register |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when set, read otherwise |
| mem_addr | output | ADDR_W | Block address |
| mem_wdata | output | 128 | Encoded block to write |
| mem_rdata | input | 128 | Block read, valid the cycle after a read strobe |

## Verification
One command can meet several rejection causes at once. A malformed source can sit behind a protected target. A malformed block can hold a value that would also overflow. The bench builds such commands on purpose and checks that the status matches the cause with the higher priority. It also checks that the register and the memory are left exactly as they were. A second command is also held on the command port while an increment is in flight. The scoreboard then sees whether an unexpected completion or write appears.

// File: rtl/vb_pkg.sv
package vb_pkg;
   localparam int VAL_W   = 32;
   localparam int BYTE_W  = 8;
   localparam int BLK_W   = 128;
   localparam int VAL_BYTES = VAL_W / BYTE_W;

   typedef enum logic [1:0] {
      OP_INC     = 2'd0,
      OP_DEC     = 2'd1,
      OP_RESTORE = 2'd2,
      OP_XFER    = 2'd3
   } vb_op_e;

   typedef enum logic [1:0] {
      ST_OK     = 2'd0,
      ST_FORMAT = 2'd1,
      ST_RANGE  = 2'd2,
      ST_PROT   = 2'd3
   } vb_status_e;

   typedef enum logic [2:0] {
      S_IDLE, S_RD, S_CHK, S_WR, S_DONE
   } vb_state_e;

   // packed MSB first: value sits in bits [31:0]
   typedef struct packed {
      logic [BYTE_W-1:0] adr_n2;
      logic [BYTE_W-1:0] adr2;
      logic [BYTE_W-1:0] adr_n;
      logic [BYTE_W-1:0] adr;
      logic [VAL_W-1:0]  val2;
      logic [VAL_W-1:0]  val_n;
      logic [VAL_W-1:0]  val;
   } vb_block_t;
endpackage

// File: rtl/vb_codec.sv
module vb_codec import vb_pkg::*; #(
   parameter int ADDR_W = 6
) (
   input  logic [BLK_W-1:0]  rd_blk,
   output logic [VAL_W-1:0]  rd_val,
   output logic              rd_ok,
   input  logic [VAL_W-1:0]  wr_val,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [BLK_W-1:0]  wr_blk
);
   vb_block_t rb, wb;
   logic [VAL_BYTES-1:0] lane_ok;
   logic                 adr_ok;

   assign rb = vb_block_t'(rd_blk);

   for (genvar i = 0; i < VAL_BYTES; i++) begin : g_lane
      logic [BYTE_W-1:0] v, vn, v2;
      assign v  = rb.val[i*BYTE_W +: BYTE_W];
      assign vn = rb.val_n[i*BYTE_W +: BYTE_W];
      assign v2 = rb.val2[i*BYTE_W +: BYTE_W];
      assign lane_ok[i] = (v == v2) && ((v ^ vn) == {BYTE_W{1'b1}});
   end

   assign adr_ok = ((rb.adr ^ rb.adr_n)  == {BYTE_W{1'b1}}) &&
                   (rb.adr == rb.adr2) &&
                   ((rb.adr ^ rb.adr_n2) == {BYTE_W{1'b1}});
   assign rd_ok  = (&lane_ok) && adr_ok;
   assign rd_val = rb.val;

   always_comb begin
      wb.val    = wr_val;
      wb.val_n  = ~wr_val;
      wb.val2   = wr_val;
      wb.adr    = BYTE_W'(wr_addr);
      wb.adr_n  = ~BYTE_W'(wr_addr);
      wb.adr2   = BYTE_W'(wr_addr);
      wb.adr_n2 = ~BYTE_W'(wr_addr);
   end
   assign wr_blk = BLK_W'(wb);
endmodule

// File: rtl/vb_alu.sv
module vb_alu import vb_pkg::*; (
   input  logic [VAL_W-1:0] a,
   input  logic [VAL_W-1:0] b,
   input  logic             sub,
   output logic [VAL_W-1:0] y,
   output logic             ovf
);
   logic [VAL_W-1:0] bb;
   assign bb  = sub ? ~b : b;
   assign y   = a + bb + VAL_W'(sub);
   assign ovf = (a[VAL_W-1] == bb[VAL_W-1]) && (y[VAL_W-1] != a[VAL_W-1]);
endmodule

// File: rtl/vb_guard.sv
module vb_guard #(
   parameter int ADDR_W        = 6,
   parameter int SECTOR_BLOCKS = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              locked
);
   localparam int SEC_LG = $clog2(SECTOR_BLOCKS);

   if (SECTOR_BLOCKS < 2 || (1 << SEC_LG) != SECTOR_BLOCKS || SEC_LG > ADDR_W) begin : g_bad_sector
      $error("vb_guard: SECTOR_BLOCKS must be a power of two between 2 and 2**ADDR_W");
   end

   assign locked = (addr == '0) || (addr[SEC_LG-1:0] == {SEC_LG{1'b1}});
endmodule

// File: rtl/vb_engine.sv
module vb_engine import vb_pkg::*; #(
   parameter int ADDR_W        = 6,
   parameter int SECTOR_BLOCKS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_blk,
   input  logic [ADDR_W-1:0] cmd_xfer,
   input  logic [31:0]       cmd_operand,
   output logic              done,
   output logic [1:0]        status,
   output logic [31:0]       acc_value,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [127:0]      mem_wdata,
   input  logic [127:0]      mem_rdata
);
   if (ADDR_W < 2 || ADDR_W > BYTE_W) begin : g_bad_addr
      $error("vb_engine: ADDR_W must fit the 8-bit address field");
   end

   vb_state_e         state_q;
   vb_op_e            op_q;
   logic [ADDR_W-1:0] blk_q, xfer_q, wr_addr_q;
   logic [VAL_W-1:0]  opnd_q, acc_q;
   vb_status_e        st_q;

   vb_op_e            op_in;
   logic [ADDR_W-1:0] target;
   logic              target_locked, accept;
   logic [VAL_W-1:0]  rd_val, alu_y;
   logic              rd_ok, alu_ovf;

   assign op_in  = vb_op_e'(cmd_op);
   assign target = (op_in == OP_XFER) ? cmd_blk : cmd_xfer;
   assign accept = cmd_valid && (state_q == S_IDLE);

   vb_guard #(.ADDR_W(ADDR_W), .SECTOR_BLOCKS(SECTOR_BLOCKS)) u_guard (
      .addr(target), .locked(target_locked));

   vb_codec #(.ADDR_W(ADDR_W)) u_codec (
      .rd_blk(mem_rdata), .rd_val(rd_val), .rd_ok(rd_ok),
      .wr_val(acc_q), .wr_addr(wr_addr_q), .wr_blk(mem_wdata));

   vb_alu u_alu (
      .a(rd_val), .b(opnd_q), .sub(op_q == OP_DEC), .y(alu_y), .ovf(alu_ovf));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         op_q      <= OP_INC;
         blk_q     <= '0;
         xfer_q    <= '0;
         wr_addr_q <= '0;
         opnd_q    <= '0;
         acc_q     <= '0;
         st_q      <= ST_OK;
      end else begin
         case (state_q)
            S_IDLE: if (accept) begin
               op_q   <= op_in;
               blk_q  <= cmd_blk;
               xfer_q <= cmd_xfer;
               opnd_q <= cmd_operand;
               if (op_in != OP_RESTORE && target_locked) begin
                  st_q    <= ST_PROT;
                  state_q <= S_DONE;
               end else if (op_in == OP_XFER) begin
                  wr_addr_q <= cmd_blk;
                  st_q      <= ST_OK;
                  state_q   <= S_WR;
               end else begin
                  state_q <= S_RD;
               end
            end
            S_RD: state_q <= S_CHK;
            S_CHK: begin
               if (!rd_ok) begin
                  st_q    <= ST_FORMAT;
                  state_q <= S_DONE;
               end else if (op_q == OP_RESTORE) begin
                  acc_q   <= rd_val;
                  st_q    <= ST_OK;
                  state_q <= S_DONE;
               end else if (alu_ovf) begin
                  st_q    <= ST_RANGE;
                  state_q <= S_DONE;
               end else begin
                  acc_q     <= alu_y;
                  wr_addr_q <= xfer_q;
                  st_q      <= ST_OK;
                  state_q   <= S_WR;
               end
            end
            S_WR:   state_q <= S_DONE;
            S_DONE: state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign cmd_ready = (state_q == S_IDLE);
   assign done      = (state_q == S_DONE);
   assign status    = st_q;
   assign acc_value = acc_q;
   assign mem_en    = (state_q == S_RD) || (state_q == S_WR);
   assign mem_we    = (state_q == S_WR);
   assign mem_addr  = (state_q == S_WR) ? wr_addr_q : blk_q;
endmodule

// File: rtl/vb_engine_chk.sv
module vb_engine_chk #(
   parameter int ADDR_W        = 6,
   parameter int SECTOR_BLOCKS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ready,
   input logic              done,
   input logic [1:0]        status,
   input logic [31:0]       acc_value,
   input logic              mem_en,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [127:0]      mem_wdata
);
   localparam int SEC_LG = $clog2(SECTOR_BLOCKS);

   p_wr_layout_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> ((mem_wdata[63:32] == ~mem_wdata[31:0]) &&
                              (mem_wdata[95:64] == mem_wdata[31:0]) &&
                              (mem_wdata[103:96] == 8'(mem_addr)) &&
                              (mem_wdata[111:104] == ~8'(mem_addr)) &&
                              (mem_wdata[119:112] == 8'(mem_addr)) &&
                              (mem_wdata[127:120] == ~8'(mem_addr))));

   p_no_locked_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> ((mem_addr != '0) &&
                              (mem_addr[SEC_LG-1:0] != {SEC_LG{1'b1}})));

   p_err_keeps_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status != 2'd0) |-> $stable(acc_value));

   p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> !cmd_ready);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_ready_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> cmd_ready);

   p_write_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_en);
endmodule

bind vb_engine vb_engine_chk #(.ADDR_W(ADDR_W), .SECTOR_BLOCKS(SECTOR_BLOCKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .done(done), .status(status),
   .acc_value(acc_value), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata));

// File: tb/vb_engine_test.sv
module vb_engine_test;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [1:0]    cmd_op = 2'd0;
   logic [AW-1:0] cmd_blk = '0;
   logic [AW-1:0] cmd_xfer = '0;
   logic [31:0]   cmd_operand = '0;
   logic          done;
   logic [1:0]    status;
   logic [31:0]   acc_value;
   logic          mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [127:0]  mem_wdata;
   logic [127:0]  mem_rdata = '0;

   always #5 clk = ~clk;

   vb_engine #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_xfer(cmd_xfer), .cmd_operand(cmd_operand),
      .done(done), .status(status), .acc_value(acc_value), .mem_en(mem_en),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

   // block memory model
   logic [127:0] bmem [64];
   int           wr_count = 0;
   longint       cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_en) begin
         if (mem_we) begin
            bmem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
         end else begin
            mem_rdata <= bmem[mem_addr];
         end
      end
   end

   function automatic logic [127:0] enc(input logic [31:0] v, input logic [7:0] a);
      return {~a, a, ~a, a, v, ~v, v};
   endfunction

   typedef struct {
      logic [1:0]  st;
      logic [31:0] acc;
      longint      t0;
      int          lat;
      string       req;
   } exp_t;
   exp_t q[$];
   int total = 0;
   int bad = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: pop an expected completion on every done pulse
   always @(negedge clk) begin : mon
      exp_t e;
      if (rst_n && done) begin
         if (q.size() == 0) begin
            check(1'b0, "R10", "unexpected done", 128'(status), 128'(0));
         end else begin
            e = q.pop_front();
            check(status == e.st, e.req, "status", 128'(status), 128'(e.st));
            check(acc_value == e.acc, e.req, "acc_value", 128'(acc_value), 128'(e.acc));
            check((cyc - e.t0) == longint'(e.lat + 1), "R11", "done latency",
                  128'(cyc - e.t0), 128'(e.lat + 1));
         end
      end
   end

   // drive one command, optionally poking the port while busy
   task automatic issue(input logic [1:0] op, input int blk, input int xfer,
                        input logic [31:0] opnd, input logic [1:0] st,
                        input logic [31:0] acc, input int lat, input int writes,
                        input bit poke, input string req);
      exp_t e;
      int   w0;
      @(negedge clk);
      w0 = wr_count;
      e.st = st; e.acc = acc; e.t0 = cyc; e.lat = lat; e.req = req;
      q.push_back(e);
      cmd_valid = 1'b1; cmd_op = op; cmd_blk = AW'(blk); cmd_xfer = AW'(xfer);
      cmd_operand = opnd;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (poke) begin
         cmd_valid = 1'b1; cmd_op = 2'd3; cmd_blk = AW'(10);
         check(cmd_ready == 1'b0, "R10", "ready while busy", 128'(cmd_ready), 128'(0));
         @(negedge clk);
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      while (q.size() != 0) @(posedge clk);
      @(negedge clk);
      check(cmd_ready == 1'b1, "R11", "ready after done", 128'(cmd_ready), 128'(1));
      check(wr_count - w0 == writes, req, "write count", 128'(wr_count - w0), 128'(writes));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      check(1'b0, "R11", "watchdog expired", 128'(0), 128'(1));
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 64; i++) bmem[i] = enc(32'd0, 8'(i));
      bmem[1]  = enc(32'd100, 8'd1);
      bmem[2]  = enc(32'h7FFF_FFF0, 8'd2);
      bmem[5]  = enc(32'h7FFF_FFFF, 8'd5) ^ (128'h01 << 32);
      bmem[6]  = enc(-32'sd20, 8'd6);
      bmem[9]  = enc(32'd7, 8'd9);
      bmem[13] = enc(32'h8000_0005, 8'd13);

      repeat (3) @(negedge clk);
      check(cmd_ready == 1'b1, "R1", "reset ready", 128'(cmd_ready), 128'(1));
      check(done == 1'b0, "R1", "reset done", 128'(done), 128'(0));
      check(acc_value == 32'd0, "R1", "reset acc", 128'(acc_value), 128'(0));
      check(mem_en == 1'b0, "R1", "reset mem_en", 128'(mem_en), 128'(0));
      rst_n = 1'b1;

      // R3 increment 100 + 25 -> block 4
      issue(2'd0, 1, 4, 32'd25, 2'd0, 32'd125, 3, 1, 1'b0, "R3");
      check(bmem[4] == enc(32'd125, 8'd4), "R2", "encoded block 4", bmem[4], enc(32'd125, 8'd4));
      // R3 increment with a negative operand, in place
      issue(2'd0, 4, 4, -32'sd10, 2'd0, 32'd115, 3, 1, 1'b0, "R3");
      check(bmem[4] == enc(32'd115, 8'd4), "R3", "block 4 after add", bmem[4], enc(32'd115, 8'd4));
      // R4 decrement -20 - 30 -> block 8, with a busy poke (R10)
      issue(2'd1, 6, 8, 32'd30, 2'd0, -32'sd50, 3, 1, 1'b1, "R4");
      check(bmem[8] == enc(-32'sd50, 8'd8), "R4", "block 8", bmem[8], enc(-32'sd50, 8'd8));
      check(bmem[10] == enc(32'd0, 8'd10), "R10", "poked block untouched", bmem[10], enc(32'd0, 8'd10));
      // R6 overflow and underflow
      issue(2'd0, 2, 10, 32'h20, 2'd2, -32'sd50, 2, 0, 1'b0, "R6");
      issue(2'd1, 13, 12, 32'd10, 2'd2, -32'sd50, 2, 0, 1'b0, "R6");
      check(bmem[10] == enc(32'd0, 8'd10), "R6", "no write on overflow", bmem[10], enc(32'd0, 8'd10));
      // R7 malformed source that would also overflow: format wins
      issue(2'd0, 5, 12, 32'd1, 2'd1, -32'sd50, 2, 0, 1'b0, "R7");
      check(bmem[12] == enc(32'd0, 8'd12), "R7", "no write on bad format", bmem[12], enc(32'd0, 8'd12));
      // R5 protected targets, including a malformed source behind a trailer
      issue(2'd0, 1, 3, 32'd1, 2'd3, -32'sd50, 0, 0, 1'b0, "R5");
      issue(2'd1, 1, 0, 32'd1, 2'd3, -32'sd50, 0, 0, 1'b0, "R5");
      issue(2'd3, 7, 0, 32'd0, 2'd3, -32'sd50, 0, 0, 1'b0, "R5");
      issue(2'd0, 5, 7, 32'd1, 2'd3, -32'sd50, 0, 0, 1'b0, "R5");
      check(bmem[3] == enc(32'd0, 8'd3), "R5", "trailer untouched", bmem[3], enc(32'd0, 8'd3));
      check(bmem[0] == enc(32'd0, 8'd0), "R5", "block 0 untouched", bmem[0], enc(32'd0, 8'd0));
      // R8 restore, then a malformed restore
      issue(2'd2, 9, 0, 32'd0, 2'd0, 32'd7, 2, 0, 1'b0, "R8");
      issue(2'd2, 5, 0, 32'd0, 2'd1, 32'd7, 2, 0, 1'b0, "R7");
      // R9 transfer
      issue(2'd3, 10, 0, 32'd0, 2'd0, 32'd7, 1, 1, 1'b0, "R9");
      check(bmem[10] == enc(32'd7, 8'd10), "R9", "transferred block", bmem[10], enc(32'd7, 8'd10));

      repeat (4) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule